// File: doc/BRIEF.md
# Two-Rank Crosspoint Routing Register

This block holds the routing program of an eight-output, eight-input crosspoint switch. Each output either takes one of the eight inputs or is switched off, and any number of outputs may take the same input. The program is written into a staging rank first, which has no effect on the live routing. A single update strobe then copies the whole staging rank into a live rank, so every output changes in the same cycle.

The staging rank can be filled in two ways. A serial path shifts a 32-bit chain in one bit per enabled clock. Its far end drives a serial output, so several devices can share one data line in a daisy chain. A parallel path rewrites one output's entry from an address and a data word. Reset clears only the live rank, which switches every output off. Whatever is staged survives reset and can be applied later with an update.

Top module: `xpt_cfg_top`

## Requirements
- R1: Each output o has a 4-bit entry. Bit 3 is the enable and bits 2:0 are the input index. Live values appear as `route_en[o]` and `route_sel[3*o+2:3*o]`. Different outputs may hold the same index.
- R2: Serial shifts and parallel writes change only the staging rank. `route_en` and `route_sel` change only in the cycle after an edge where `upd` or `rst` is high.
- R3: When `upd` is sampled high, all eight staged entries are copied into the live rank together. They are visible after that edge.
- R4: When `upd` and a load are sampled at the same edge, the live rank takes the staging contents from before that load. The load still lands in the staging rank.
- R5: When `ser_mode` and `ser_shift` are both high at a rising edge, the staging chain shifts by one. Chain bit 0 takes `ser_din` and chain bit k takes bit k-1. Chain bit 4*o+f holds field f of output o. After 32 shifts, the first bit shifted in is the enable of output 7, and each entry arrives MSB first.
- R6: `ser_dout` always equals chain bit 31. As a result, a bit shifted in reappears at `ser_dout` after 32 shifts, in the same order, ready for the next device.
- R7: When `ser_mode` is low and `par_wr` is high, the entry selected by `par_addr` takes `par_data`. All other entries keep their values.
- R8: `par_wr` has no effect while `ser_mode` is high. `ser_shift` has no effect while `ser_mode` is low.
- R9: When `rst` is high at a rising edge, the live rank is cleared, so every enable and select reads 0 after that edge. Reset takes priority over `upd`. The staging rank keeps its contents.
- R10: An output whose live enable is 0 reports select 0, whatever index its staged entry carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the live rank |
| ser_mode | input | 1 | High selects the serial load path, low selects the parallel path |
| ser_shift | input | 1 | Shift enable for the staging chain (serial mode) |
| ser_din | input | 1 | Serial data into chain bit 0 |
| ser_dout | output | 1 | Chain bit 31, for daisy-chaining |
| par_wr | input | 1 | Parallel write strobe (parallel mode) |
| par_addr | input | 3 | Output whose staged entry is written |
| par_data | input | 4 | Entry value: bit 3 enable, bits 2:0 input index |
| upd | input | 1 | Global update: staging rank to live rank |
| route_en | output | 8 | Live enable for each output |
| route_sel | output | 24 | Live input index for each output, 3 bits per output |

## Verification
The live outputs are registers, so the result of an update or a reset is due one cycle after the edge that samples it. Staging changes are due at the same edge, and the bench observes them through `ser_dout` or through a later update. The bench drives every input at a falling edge and lets the rising edge sample it. It then compares all outputs with its model at the next falling edge, which is exactly one register stage later. For daisy-chain order it also checks `ser_dout` before each shift edge against the bit expected 32 shifts back. Load-only cycles are checked to leave the live outputs untouched.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int unsigned DEF_OUTS = 8;
  localparam int unsigned DEF_INS  = 8;

  // which path writes the staging rank in a cycle
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_SHIFT = 2'd1,
    LD_WRITE = 2'd2
  } ld_kind_e;
endpackage

// File: rtl/xpt_stage_rank.sv
module xpt_stage_rank
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT = DEF_OUTS,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned ENT_W   = SEL_W + 1,
  localparam int unsigned CHAIN_W = NUM_OUT * ENT_W,
  localparam int unsigned ADDR_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               ser_mode,
  input  logic               ser_shift,
  input  logic               ser_din,
  input  logic               par_wr,
  input  logic [ADDR_W-1:0]  par_addr,
  input  logic [ENT_W-1:0]   par_data,
  output logic [CHAIN_W-1:0] stage_q,
  output logic               ser_dout
);
  ld_kind_e           kind;
  logic [CHAIN_W-1:0] stage_d;

  // the mode pin picks one path; the other path's strobe is ignored
  always_comb begin
    if (ser_mode) kind = ser_shift ? LD_SHIFT : LD_IDLE;
    else          kind = par_wr    ? LD_WRITE : LD_IDLE;
  end

  always_comb begin
    stage_d = stage_q;
    case (kind)
      LD_SHIFT: stage_d = {stage_q[CHAIN_W-2:0], ser_din};
      LD_WRITE: begin
        for (int o = 0; o < NUM_OUT; o++) begin
          if (par_addr == ADDR_W'(o)) stage_d[o*ENT_W +: ENT_W] = par_data;
        end
      end
      default: stage_d = stage_q;
    endcase
  end

  // no reset: staged program must survive a live-rank reset
  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  assign ser_dout = stage_q[CHAIN_W-1];
endmodule

// File: rtl/xpt_live_rank.sv
module xpt_live_rank #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned ENT_W   = SEL_W + 1,
  localparam int unsigned CHAIN_W = NUM_OUT * ENT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [CHAIN_W-1:0]       stage_q,
  output logic [NUM_OUT-1:0]       route_en,
  output logic [NUM_OUT*SEL_W-1:0] route_sel
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic             en_r;
    logic [SEL_W-1:0] sel_r;
    logic             st_en;
    logic [SEL_W-1:0] st_sel;

    assign st_en  = stage_q[g*ENT_W + SEL_W];
    assign st_sel = stage_q[g*ENT_W +: SEL_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r  <= 1'b0;
        sel_r <= '0;
      end else if (upd) begin
        en_r  <= st_en;
        sel_r <= st_en ? st_sel : '0;
      end
    end

    assign route_en[g]                  = en_r;
    assign route_sel[g*SEL_W +: SEL_W]  = sel_r;
  end
endmodule

// File: rtl/xpt_cfg_top.sv
module xpt_cfg_top
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT = DEF_OUTS,
  parameter int unsigned NUM_IN  = DEF_INS,
  localparam int unsigned SEL_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned ENT_W   = SEL_W + 1,
  localparam int unsigned CHAIN_W = NUM_OUT * ENT_W,
  localparam int unsigned ADDR_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_mode,
  input  logic                     ser_shift,
  input  logic                     ser_din,
  output logic                     ser_dout,
  input  logic                     par_wr,
  input  logic [ADDR_W-1:0]        par_addr,
  input  logic [ENT_W-1:0]         par_data,
  input  logic                     upd,
  output logic [NUM_OUT-1:0]       route_en,
  output logic [NUM_OUT*SEL_W-1:0] route_sel
);
  logic [CHAIN_W-1:0] stage_q;

  xpt_stage_rank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_stage (
    .clk      (clk),
    .ser_mode (ser_mode),
    .ser_shift(ser_shift),
    .ser_din  (ser_din),
    .par_wr   (par_wr),
    .par_addr (par_addr),
    .par_data (par_data),
    .stage_q  (stage_q),
    .ser_dout (ser_dout)
  );

  xpt_live_rank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_live (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd),
    .stage_q  (stage_q),
    .route_en (route_en),
    .route_sel(route_sel)
  );
endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_IN  = 8,
  localparam int unsigned SEL_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned ENT_W   = SEL_W + 1,
  localparam int unsigned CHAIN_W = NUM_OUT * ENT_W,
  localparam int unsigned ADDR_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ser_mode,
  input logic                     ser_shift,
  input logic                     ser_din,
  input logic                     par_wr,
  input logic [ADDR_W-1:0]        par_addr,
  input logic [ENT_W-1:0]         par_data,
  input logic                     upd,
  input logic [NUM_OUT-1:0]       route_en,
  input logic [NUM_OUT*SEL_W-1:0] route_sel,
  input logic [CHAIN_W-1:0]       stage_q
);
  logic [NUM_OUT-1:0]       want_en;
  logic [NUM_OUT*SEL_W-1:0] want_sel;
  logic [NUM_OUT*SEL_W-1:0] en_spread;
  logic                     any_ld;

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      want_en[o] = stage_q[o*ENT_W + SEL_W];
      for (int b = 0; b < SEL_W; b++) begin
        want_sel[o*SEL_W + b]  = want_en[o] & stage_q[o*ENT_W + b];
        en_spread[o*SEL_W + b] = route_en[o];
      end
    end
  end

  assign any_ld = ser_mode ? ser_shift : par_wr;

  // R2
  hold_live_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(route_en) && $stable(route_sel)));

  // R3 R4
  copy_all_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (route_en == $past(want_en) && route_sel == $past(want_sel)));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && ser_shift) |=>
      (stage_q == {$past(stage_q[CHAIN_W-2:0]), $past(ser_din)}));

  // R7
  par_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_mode && par_wr) |=>
      (stage_q[$past(par_addr)*ENT_W +: ENT_W] == $past(par_data)));

  // R8
  idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !any_ld |=> $stable(stage_q));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (route_en == '0 && route_sel == '0));

  // R9
  rst_keep_chk: assert property (@(posedge clk)
    (rst && !any_ld) |=> $stable(stage_q));

  // R10
  off_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (route_sel & ~en_spread) == '0);
endmodule

bind xpt_cfg_top xpt_cfg_chk #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_mode (ser_mode),
  .ser_shift(ser_shift),
  .ser_din  (ser_din),
  .par_wr   (par_wr),
  .par_addr (par_addr),
  .par_data (par_data),
  .upd      (upd),
  .route_en (route_en),
  .route_sel(route_sel),
  .stage_q  (stage_q)
);

// File: tb/sim_xpt_cfg_top.sv
module sim_xpt_cfg_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_mode = 1'b0, ser_shift = 1'b0, ser_din = 1'b0;
  logic        par_wr = 1'b0, upd = 1'b0;
  logic [2:0]  par_addr = '0;
  logic [3:0]  par_data = '0;
  logic        ser_dout;
  logic [7:0]  route_en;
  logic [23:0] route_sel;

  int total = 0;
  int bad   = 0;

  logic [31:0] m1 = '0;   // staging model
  logic [7:0]  m_en = '0;
  logic [23:0] m_sel = '0;
  bit          staged = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xpt_cfg_top u0 (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .ser_shift(ser_shift),
    .ser_din(ser_din), .ser_dout(ser_dout), .par_wr(par_wr),
    .par_addr(par_addr), .par_data(par_data), .upd(upd),
    .route_en(route_en), .route_sel(route_sel)
  );

  function automatic logic [7:0] en_of(input logic [31:0] s);
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = s[4*o+3];
    return r;
  endfunction

  function automatic logic [23:0] sel_of(input logic [31:0] s);
    logic [23:0] r;
    for (int o = 0; o < 8; o++) r[3*o +: 3] = s[4*o+3] ? s[4*o +: 3] : 3'd0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {24'd0, route_en}, {24'd0, m_en});
    chk(req, {8'd0, route_sel}, {8'd0, m_sel});
    if (staged) chk("R6", {31'd0, ser_dout}, {31'd0, m1[31]});
  endtask

  // drive at falling edge, let the rising edge sample, check at next falling edge
  task automatic cyc(input logic r, input logic sm, input logic ss, input logic sd,
                     input logic pw, input logic [2:0] pa, input logic [3:0] pd,
                     input logic u);
    rst = r; ser_mode = sm; ser_shift = ss; ser_din = sd;
    par_wr = pw; par_addr = pa; par_data = pd; upd = u;
    @(posedge clk);
    if (r) begin
      m_en = '0; m_sel = '0;
    end else if (u) begin
      m_en = en_of(m1); m_sel = sel_of(m1);
    end
    if (sm && ss) m1 = {m1[30:0], sd};
    else if (!sm && pw) m1[4*pa +: 4] = pd;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0,0,0,0,0,3'd0,4'd0,0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(1,0,0,0,0,3'd0,4'd0,0);
    cyc(1,0,0,0,0,3'd0,4'd0,1);
    check_all("R9 reset state");

    // R7 parallel load; R2 live rank untouched; R10 output 2 disabled with index 5
    for (int o = 0; o < 8; o++) begin
      logic [3:0] d;
      d = (o == 2) ? 4'b0101 : {1'b1, 3'(7 - o)};
      if (o == 3) d = 4'b1011;   // R1 outputs 3 and 4 share input 3
      cyc(0,0,0,0,1,3'(o),d,0);
      check_all("R2 load only");
    end
    staged = 1'b1;
    cyc(0,0,0,0,0,3'd0,4'd0,1);
    check_all("R3 update");
    chk("R1 shared input", {29'd0, route_sel[9 +: 3]}, {29'd0, route_sel[12 +: 3]});
    chk("R10 disabled sel", {29'd0, route_sel[6 +: 3]}, 32'd0);
    chk("R7 entry 5", {28'd0, route_en[5], route_sel[15 +: 3]}, {28'd0, 4'b1010});

    // R4 write and update together
    cyc(0,0,0,0,1,3'd0,4'b1001,1);
    check_all("R4 same cycle");
    chk("R4 old entry 0", {29'd0, route_sel[0 +: 3]}, 32'd7);
    idle();
    cyc(0,0,0,0,0,3'd0,4'd0,1);
    chk("R4 new entry 0", {29'd0, route_sel[0 +: 3]}, 32'd1);

    // R8 cross-mode strobes ignored
    cyc(0,1,0,0,1,3'd1,4'b0000,0);
    cyc(0,0,1,1,0,3'd0,4'd0,0);
    cyc(0,0,0,0,0,3'd0,4'd0,1);
    check_all("R8 ignored strobes");
    chk("R8 entry 1 kept", {31'd0, route_en[1]}, 32'd1);

    // R5 serial load of a full chain, MSB of output 7 first
    w = $urandom();
    for (int k = 31; k >= 0; k--) begin
      cyc(0,1,1,w[k],0,3'd0,4'd0,0);
      check_all("R5 shifting");
    end
    cyc(0,1,0,0,0,3'd0,4'd0,1);
    chk("R5 enables", {24'd0, route_en}, {24'd0, en_of(w)});
    chk("R5 selects", {8'd0, route_sel}, {8'd0, sel_of(w)});

    // R6 chain passes bits out in the order they went in
    for (int k = 31; k >= 0; k--) begin
      chk("R6 pass-through", {31'd0, ser_dout}, {31'd0, w[k]});
      cyc(0,1,1,1'b0,0,3'd0,4'd0,0);
    end

    // R9 reset beats update, staging kept
    cyc(0,0,0,0,1,3'd6,4'b1100,0);
    cyc(1,0,0,0,0,3'd0,4'd0,1);
    check_all("R9 reset over update");
    chk("R9 enables cleared", {24'd0, route_en}, 32'd0);
    cyc(0,0,0,0,0,3'd0,4'd0,1);
    check_all("R9 staging kept");
    chk("R9 entry 6", {28'd0, route_en[6], route_sel[18 +: 3]}, {28'd0, 4'b1100});

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic r, sm;
      r  = ($urandom_range(63) == 0);
      sm = ($urandom_range(2) == 0);
      cyc(r, sm, 1'($urandom()), 1'($urandom()), 1'($urandom()),
          3'($urandom()), 4'($urandom()), ($urandom_range(3) == 0));
      check_all("R2/R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule